// File: doc/BRIEF.md
# External Bus Wait-State Controller

This controller runs one external memory bus cycle at a time for an internal requester. The cycle length has two inputs. A programmed minimum wait-state count sets the shortest cycle. An active-low transfer-acknowledge pin from the addressed device can stretch the cycle for as long as the device needs. The controller drives a cycle-active flag and an active-low strobe for the whole cycle. It returns a one-clock completion pulse when the cycle ends, then rests for an idle clock so the device can release its acknowledge.

The acknowledge pin can be used in one of two ways. It can be taken straight into the completion decision when the device is clocked from the bus clock. It can instead pass through a two-flop synchronizer when the device is asynchronous, which delays it by two clocks. Two kinds of cycle cannot be stretched and always run for exactly the programmed count: cycles programmed with zero wait states, and cycles flagged as DRAM-type. The acknowledge is looked at only while this side owns the bus and a cycle is running.

Top module: `ext_bus_waitctl`

## Requirements
- R1: While `rst` is high, and after it is released until a cycle starts, `cyc_active` is 0, `strobe_n` is 1 and `done` is 0.
- R2: A cycle starts only from idle, and only when `req_valid` and `bus_owner` are both high at a clock edge. `cyc_active` is high from the next clock. A request made without bus ownership starts nothing.
- R3: With N = `wait_cfg` (latched at the start) and the acknowledge already seen in the first active clock, `cyc_active` stays high for exactly N+1 clocks.
- R4: With N = 0, the cycle lasts exactly one clock whatever `ta_n` does.
- R5: With N ≥ 1 on a non-DRAM cycle, an acknowledge that is never seen keeps the cycle active without limit. If the acknowledge is first seen in active clock j, the cycle lasts max(N+1, j+1) clocks.
- R6: An acknowledge seen before the minimum count runs out is held, even if `ta_n` returns high. The cycle then ends after exactly N+1 clocks.
- R7: `ta_async`=0 samples `ta_n` directly: a low level driven during active clock A is seen in clock A. `ta_async`=1 passes it through two flops, so it is seen in clock A+2. Clock 0 is the request clock.
- R8: When `req_dram` is high at the start, the cycle lasts exactly N+1 clocks and `ta_n` is ignored.
- R9: Changing `wait_cfg` during a cycle does not change that cycle's length.
- R10: `ta_n` low while idle, or while `bus_owner` is 0 during a cycle, is not remembered and does not end the cycle.
- R11: `done` is high for exactly one clock, the first clock after the last active clock. No cycle starts in that clock, so at least one idle clock separates cycles.
- R12: `strobe_n` is always the inverse of `cyc_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Cycle request from the internal master |
| req_dram | input | 1 | Requested cycle is DRAM-type (no acknowledge stretching) |
| wait_cfg | input | WS_W | Programmed minimum wait-state count |
| ta_async | input | 1 | 1: acknowledge goes through the synchronizer; 0: sampled directly |
| bus_owner | input | 1 | This side currently owns the external bus |
| ta_n | input | 1 | Transfer acknowledge from the device, active low |
| cyc_active | output | 1 | External cycle in progress |
| strobe_n | output | 1 | Bus strobe, active low |
| done | output | 1 | One-clock completion pulse to the requester |

## Verification
The hardest case to reach is an acknowledge that arrives and goes away again before the minimum count has run out. The pin shows nothing by the time the cycle may end, so only the held flag can let the cycle finish. The bench drives a one-clock low pulse on `ta_n` in the first active clock of a four-wait-state cycle and expects exactly five active clocks. Other tests lower `ta_n` during idle, or while bus ownership is withdrawn in the middle of a cycle, and then show through the cycle length that none of that was remembered.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_DONE = 2'd2
  } ebw_state_e;

endpackage

// File: rtl/ebw_ack_sync.sv
// Multi-stage synchronizer for the acknowledge level (asserted-high input).
module ebw_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_in,
  output logic ack_out
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= ack_in;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign ack_out = chain[STAGES-1];

endmodule

// File: rtl/ebw_wait_cnt.sv
// Minimum wait-state down-counter, loaded at cycle start.
module ebw_wait_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         is_zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/ebw_ack_latch.sv
// Holds an acknowledge seen at any point of the running cycle.
module ebw_ack_latch (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sample,
  input  logic ack,
  output logic pend
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (clear) begin
      pend <= 1'b0;
    end else if (sample && ack) begin
      pend <= 1'b1;
    end
  end

endmodule

// File: rtl/ext_bus_waitctl.sv
module ext_bus_waitctl
  import ebw_pkg::*;
#(
  parameter int WS_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_dram,
  input  logic [WS_W-1:0] wait_cfg,
  input  logic            ta_async,
  input  logic            bus_owner,
  input  logic            ta_n,
  output logic            cyc_active,
  output logic            strobe_n,
  output logic            done
);

  ebw_state_e state_q;
  logic       ext_en_q;
  logic       ack_raw;
  logic       ack_synced;
  logic       ack_eff;
  logic       min_done;
  logic       ack_pend;
  logic       start_c;
  logic       finish_c;
  logic       sample_c;

  assign ack_raw = ~ta_n;

  ebw_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .ack_in  (ack_raw),
    .ack_out (ack_synced)
  );

  assign ack_eff = ta_async ? ack_synced : ack_raw;

  assign start_c  = (state_q == ST_IDLE) && req_valid && bus_owner;
  assign sample_c = (state_q == ST_ACT) && ext_en_q && bus_owner;
  assign finish_c = (state_q == ST_ACT) && min_done && (!ext_en_q || ack_pend);

  ebw_wait_cnt #(.W(WS_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (start_c),
    .load_val (wait_cfg),
    .is_zero  (min_done)
  );

  ebw_ack_latch u_pend (
    .clk    (clk),
    .rst    (rst),
    .clear  (start_c),
    .sample (sample_c),
    .ack    (ack_eff),
    .pend   (ack_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ext_en_q   <= 1'b0;
      cyc_active <= 1'b0;
      strobe_n   <= 1'b1;
      done       <= 1'b0;
    end else begin
      done <= finish_c;
      unique case (state_q)
        ST_IDLE: begin
          if (start_c) begin
            state_q    <= ST_ACT;
            ext_en_q   <= (wait_cfg != '0) && !req_dram;
            cyc_active <= 1'b1;
            strobe_n   <= 1'b0;
          end
        end
        ST_ACT: begin
          if (finish_c) begin
            state_q    <= ST_DONE;
            cyc_active <= 1'b0;
            strobe_n   <= 1'b1;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
  parameter int WS_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_dram,
  input logic [WS_W-1:0] wait_cfg,
  input logic            bus_owner,
  input logic            cyc_active,
  input logic            strobe_n,
  input logic            done
);

  int              len_q;
  logic [WS_W-1:0] n_cap;
  logic            dram_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= 0;
      n_cap    <= '0;
      dram_cap <= 1'b0;
    end else if (cyc_active) begin
      len_q <= len_q + 1;
    end else begin
      len_q    <= 0;
      n_cap    <= wait_cfg;
      dram_cap <= req_dram;
    end
  end

  AST_STROBE_INV: assert property (@(posedge clk) disable iff (rst)
    strobe_n == !cyc_active); // R12

  AST_START_OWNED: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_active) |-> $past(req_valid && bus_owner)); // R2

  AST_ZERO_WS_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    ($rose(cyc_active) && $past(wait_cfg) == '0) |=> !cyc_active); // R4

  AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(cyc_active) |-> (len_q >= int'(n_cap) + 1)); // R3

  AST_FIXED_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(cyc_active) && (dram_cap || n_cap == '0)) |-> (len_q == int'(n_cap) + 1)); // R8

  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cyc_active) && !cyc_active)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !cyc_active)); // R11

endmodule

bind ext_bus_waitctl ebw_checker #(.WS_W(WS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_dram   (req_dram),
  .wait_cfg   (wait_cfg),
  .bus_owner  (bus_owner),
  .cyc_active (cyc_active),
  .strobe_n   (strobe_n),
  .done       (done)
);

// File: tb/sim_ext_bus_waitctl.sv
`timescale 1ns/1ps
module sim_ext_bus_waitctl;

  localparam int WS_W = 5;

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid;
  logic            req_dram;
  logic [WS_W-1:0] wait_cfg;
  logic            ta_async;
  logic            bus_owner;
  logic            ta_n;
  logic            cyc_active;
  logic            strobe_n;
  logic            done;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R1";

  // reference model state
  int m_act = 0, m_done = 0, m_i = 0, m_n = 0, m_j = 0;
  bit m_ext = 1'b0, h1 = 1'b0, h2 = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  ext_bus_waitctl #(.WS_W(WS_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dram(req_dram),
    .wait_cfg(wait_cfg), .ta_async(ta_async), .bus_owner(bus_owner),
    .ta_n(ta_n), .cyc_active(cyc_active), .strobe_n(strobe_n), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: cycle length = max(N+1, j+1), j = first clock the ack is seen
  always @(posedge clk) begin
    bit raw, ack, fin;
    if (rst) begin
      m_act = 0; m_done = 0; h1 = 0; h2 = 0;
    end else begin
      raw = !ta_n;
      ack = ta_async ? h2 : raw;
      h2 = h1;
      h1 = raw;
      if (m_act != 0) begin
        fin = (m_i >= m_n + 1) && (!m_ext || (m_j != 0 && m_i > m_j));
        if (fin) begin
          m_act = 0; m_done = 1;
        end else begin
          if (m_ext && ack && bus_owner && m_j == 0) m_j = m_i;
          m_i++;
        end
      end else if (m_done != 0) begin
        m_done = 0;
      end else if (req_valid && bus_owner) begin
        m_act = 1; m_i = 1; m_n = int'(wait_cfg); m_j = 0;
        m_ext = (wait_cfg != '0) && !req_dram;
      end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(cyc_active == m_act[0], cur_tag, int'(cyc_active), m_act);
      chk(done == m_done[0], cur_tag, int'(done), m_done);
      chk(strobe_n == !m_act[0], "R12", int'(strobe_n), int'(!m_act[0]));
    end
  end

  task automatic bus_cycle(input int n, input int mid, input bit dram, input bit amode,
                           input int a_from, input int a_to, input int own_from,
                           input int exp_len, input string tag);
    int len;
    cur_tag   = tag;
    wait_cfg  = n[WS_W-1:0];
    req_dram  = dram;
    ta_async  = amode;
    bus_owner = 1'b1;
    ta_n      = !(a_from == 0);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cyc_active == 1'b1, "R2", int'(cyc_active), 1);
    len = 0;
    while (cyc_active && len < 300) begin
      len++;
      wait_cfg  = mid[WS_W-1:0];
      ta_n      = !(len >= a_from && len <= a_to);
      bus_owner = (len >= own_from);
      @(negedge clk);
    end
    ta_n = 1'b1;
    bus_owner = 1'b1;
    chk(len == exp_len, tag, len, exp_len);
    chk(done == 1'b1, "R11", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && cyc_active == 1'b0, "R11", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_dram = 1'b0; wait_cfg = '0;
    ta_async = 1'b0; bus_owner = 1'b1; ta_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cyc_active == 0 && strobe_n == 1 && done == 0, "R1", int'(cyc_active), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cyc_active == 0 && strobe_n == 1 && done == 0, "R1", int'(cyc_active), 0);

    // R2: request without bus ownership does nothing
    cur_tag = "R2";
    bus_owner = 1'b0; req_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(cyc_active == 1'b0, "R2", int'(cyc_active), 0);
    end
    req_valid = 1'b0; bus_owner = 1'b1;
    @(negedge clk);

    bus_cycle(3, 3, 0, 0, 1, 999, 1, 4, "R3");       // minimum length N+1
    bus_cycle(0, 0, 0, 0, 999, 999, 1, 1, "R4");     // zero waits, no ack ever
    bus_cycle(1, 1, 0, 0, 6, 999, 1, 7, "R5");       // ack late: j+1
    bus_cycle(2, 2, 0, 0, 40, 999, 1, 41, "R5");     // long stretch
    bus_cycle(4, 4, 0, 0, 1, 1, 1, 5, "R6");         // short early pulse held
    bus_cycle(1, 1, 0, 1, 3, 999, 1, 6, "R7");       // async: seen at A+2
    bus_cycle(2, 2, 0, 1, 0, 999, 1, 3, "R7");       // async, ack from request clock
    bus_cycle(3, 3, 1, 0, 999, 999, 1, 4, "R8");     // DRAM, no ack
    bus_cycle(2, 2, 1, 1, 999, 999, 1, 3, "R8");     // DRAM async, no ack
    bus_cycle(2, 9, 0, 0, 1, 999, 1, 3, "R9");       // mid-cycle write ignored
    bus_cycle(9, 0, 0, 0, 1, 999, 1, 10, "R9");

    // R10: ack while idle is forgotten
    cur_tag = "R10";
    ta_async = 1'b0; ta_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_cycle(1, 1, 0, 0, 5, 999, 1, 6, "R10");
    // R10: ack while bus not owned is ignored
    bus_cycle(1, 1, 0, 0, 1, 999, 4, 5, "R10");

    // R11: held request still sees a done clock and an idle clock
    cur_tag = "R11";
    wait_cfg = '0; req_dram = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk(cyc_active == 1'b1, "R11", int'(cyc_active), 1);
    @(negedge clk);
    chk(cyc_active == 1'b0 && done == 1'b1, "R11", int'(done), 1);
    @(negedge clk);
    chk(cyc_active == 1'b0 && done == 1'b0, "R11", int'(cyc_active), 0);
    @(negedge clk);
    chk(cyc_active == 1'b1, "R11", int'(cyc_active), 1);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule